// File: doc/BRIEF.md
# Split Dual 8-Bit Timer with Capture, Event Counting and PWM

This block holds two independent 8-bit up-counters that share one tick enable. The primary half runs in one of three modes: a reload timer that counts ticks, a capture timer that snapshots its count when a chosen edge arrives on an external event pin, or an event counter that counts chosen edges of that pin and ignores ticks. The secondary half is always a reload timer with a compare register. It shapes a PWM waveform, and that output has its own enable and polarity bits. Capture or counting on the primary half does not disturb the secondary half.

Each half counts up to all-ones and then reloads from its reload register. A compare hit occurs when the count steps onto the compare value. That hit can only happen when the compare value lies inside the reload-to-0xFF range. Software loads the reload, compare and control registers through one write port. Software clears the sticky flags through a clear strobe vector.

Top module: `dtm_split_timer`

## Requirements
- R1: After reset both counts, the capture register and all four flags are zero, and the PWM output is low.
- R2: When the primary half runs in timer mode, each cycle with tick_en high adds one to the count. A step taken at 0xFF loads the primary reload value instead and sets ovf_a.
- R3: When the primary half is not capturing, hit_a is set on the step that brings the count to the compare value, provided compare is at least reload. If compare is below reload, hit_a is never set by a compare.
- R4: When cnt_mode is 1, the primary count advances once per selected edge of evt_pin and ignores tick_en. The edge_sel encoding is 00 none, 01 rising, 10 falling, 11 both. The count changes on the third rising clock edge after the pin changes.
- R5: With edge_sel non-zero and cnt_mode 0, a selected edge copies the current primary count into cap_val and sets hit_a. Compare matches do not set hit_a in this mode, and unselected edges have no effect.
- R6: The secondary half counts ticks, reloads from its own reload register after 0xFF, sets ovf_b, and sets cmp_b under the same compare-range rule as R3, whatever mode the primary half is in.
- R7: The internal PWM level goes high on a secondary overflow and low on a secondary compare hit. pwm_out equals that level XOR pwm_inv when pwm_oe is 1, and is 0 when pwm_oe is 0.
- R8: Flags stay set until a 1 arrives on their bit of clr_flags: bit 0 ovf_a, bit 1 hit_a, bit 2 ovf_b, bit 3 cmp_b. A set condition in the same cycle overrides the clear.
- R9: A half whose run bit is 0 holds its count.
- R10: Writes with wr_en high load the register chosen by wr_addr: 0 primary reload, 1 primary compare, 2 secondary reload, 3 secondary compare, 4 control. The control bits are [0] run_a, [1] run_b, [2] cnt_mode, [4:3] edge_sel, [5] pwm_oe, [6] pwm_inv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled timer tick enable |
| evt_pin | input | 1 | Asynchronous external event pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| clr_flags | input | 4 | Flag clear strobes |
| cnt_a | output | 8 | Primary count |
| cnt_b | output | 8 | Secondary count |
| cap_val | output | 8 | Captured primary count |
| ovf_a | output | 1 | Primary overflow flag |
| hit_a | output | 1 | Primary compare/capture flag |
| ovf_b | output | 1 | Secondary overflow flag |
| cmp_b | output | 1 | Secondary compare flag |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check the following on every cycle: single-step increments, wrap-to-reload with its overflow flag, flags staying set until cleared, holding while stopped, compare suppression when compare is below reload, capture copying the count, and the PWM level following secondary overflow and compare. Only the bench scenarios show the edge-selection encodings and the three-cycle latency from pin to count. The same is true for output polarity and enable, and for the secondary half making PWM while the primary half captures. The bench sweeps reload and compare pairs around the suppression boundary over full count cycles.

// File: rtl/dtm_pkg.sv
// Shared types for the split timer: control register layout, edge
// selection codes and write addresses. Assumes the control word fits
// in the write data width.
package dtm_pkg;
    localparam int CTRL_W = 7;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic      pwm_inv;
        logic      pwm_oe;
        edge_sel_e edge_sel;
        logic      cnt_mode;
        logic      run_b;
        logic      run_a;
    } ctrl_t;

    typedef enum logic [2:0] {
        ADDR_RELOAD_A = 3'd0,
        ADDR_CMP_A    = 3'd1,
        ADDR_RELOAD_B = 3'd2,
        ADDR_CMP_B    = 3'd3,
        ADDR_CTRL     = 3'd4
    } addr_e;
endpackage

// File: rtl/dtm_edge_sync.sv
// Synchronises an asynchronous pin through STAGES flops and produces a
// one-cycle pulse on the edges picked by sel. Assumes STAGES >= 2 and
// that pin pulses last at least two clocks.
module dtm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  dtm_pkg::edge_sel_e sel,
    output logic              hit
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              rise;
    logic              fall;

    // Synchroniser chain, one flop per stage.
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    // Edge decode filtered by the selection code.
    always_comb begin
        rise = chain[STAGES-1] & ~prev;
        fall = ~chain[STAGES-1] & prev;
        hit  = (sel[0] & rise) | (sel[1] & fall);
    end
endmodule

// File: rtl/dtm_half.sv
// One 8-bit timer half: up-counter with reload after all-ones, a compare
// hit that only fires when compare >= reload, and sticky overflow and
// hit flags where a set wins over a clear. Assumes step is a one-cycle
// qualifier already gated by the run bit.
module dtm_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         cmp_en,
    input  logic         cap_evt,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] cmp,
    input  logic         clr_ovf,
    input  logic         clr_hit,
    output logic [W-1:0] cnt,
    output logic         ovf_flag,
    output logic         hit_flag,
    output logic         wrap,
    output logic         match
);
    logic [W-1:0] nxt;
    logic         at_top;

    // Next count value and the wrap/match events of this step.
    always_comb begin
        at_top = &cnt;
        nxt    = at_top ? reload : cnt + 1'b1;
        wrap   = step & at_top;
        match  = step & cmp_en & (cmp >= reload) & (nxt == cmp);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (step) cnt <= nxt;
    end

    // Sticky overflow flag, set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (wrap)    ovf_flag <= 1'b1;
        else if (clr_ovf) ovf_flag <= 1'b0;
    end

    // Sticky compare/capture flag, set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               hit_flag <= 1'b0;
        else if (match | cap_evt) hit_flag <= 1'b1;
        else if (clr_hit)         hit_flag <= 1'b0;
    end
endmodule

// File: rtl/dtm_pwm.sv
// PWM shaper: level rises on a timer wrap and falls on a compare hit
// (compare wins when both coincide); output is gated and inverted.
module dtm_pwm (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic match,
    input  logic oe,
    input  logic inv,
    output logic level,
    output logic pwm_out
);
    // Waveform level register.
    always_ff @(posedge clk) begin
        if (!rst_n)     level <= 1'b0;
        else if (match) level <= 1'b0;
        else if (wrap)  level <= 1'b1;
    end

    // Output gating and polarity.
    always_comb pwm_out = oe & (level ^ inv);
endmodule

// File: rtl/dtm_split_timer.sv
// Split dual 8-bit timer. The primary half is a timer, a capture timer or
// an edge counter on evt_pin. The secondary half is a timer driving a PWM
// output. Holds the configuration registers. Assumes W >= control width.
module dtm_split_timer
    import dtm_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         evt_pin,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [3:0]   clr_flags,
    output logic [W-1:0] cnt_a,
    output logic [W-1:0] cnt_b,
    output logic [W-1:0] cap_val,
    output logic         ovf_a,
    output logic         hit_a,
    output logic         ovf_b,
    output logic         cmp_b,
    output logic         pwm_out
);
    ctrl_t        ctrl_q;
    logic [W-1:0] rel_a;
    logic [W-1:0] cmpv_a;
    logic [W-1:0] rel_b;
    logic [W-1:0] cmpv_b;
    logic         edge_hit;
    logic         cap_mode;
    logic         step_a;
    logic         step_b;
    logic         cap_evt;
    logic         wrap_a;
    logic         match_a;
    logic         wrap_b;
    logic         match_b;
    logic         pwm_lvl;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rel_a  <= '0;
            cmpv_a <= '0;
            rel_b  <= '0;
            cmpv_b <= '0;
        end else if (wr_en) begin
            case (addr_e'(wr_addr))
                ADDR_RELOAD_A: rel_a  <= wr_data;
                ADDR_CMP_A:    cmpv_a <= wr_data;
                ADDR_RELOAD_B: rel_b  <= wr_data;
                ADDR_CMP_B:    cmpv_b <= wr_data;
                ADDR_CTRL:     ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:       ;
            endcase
        end
    end

    // Mode decode and step qualifiers for both halves.
    always_comb begin
        cap_mode = (ctrl_q.edge_sel != EDGE_NONE) && !ctrl_q.cnt_mode;
        step_a   = ctrl_q.run_a & (ctrl_q.cnt_mode ? edge_hit : tick_en);
        cap_evt  = cap_mode & edge_hit;
        step_b   = ctrl_q.run_b & tick_en;
    end

    dtm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (evt_pin),
        .sel   (ctrl_q.edge_sel),
        .hit   (edge_hit)
    );

    dtm_half #(.W(W)) u_half_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step_a),
        .cmp_en   (!cap_mode),
        .cap_evt  (cap_evt),
        .reload   (rel_a),
        .cmp      (cmpv_a),
        .clr_ovf  (clr_flags[0]),
        .clr_hit  (clr_flags[1]),
        .cnt      (cnt_a),
        .ovf_flag (ovf_a),
        .hit_flag (hit_a),
        .wrap     (wrap_a),
        .match    (match_a)
    );

    dtm_half #(.W(W)) u_half_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step_b),
        .cmp_en   (1'b1),
        .cap_evt  (1'b0),
        .reload   (rel_b),
        .cmp      (cmpv_b),
        .clr_ovf  (clr_flags[2]),
        .clr_hit  (clr_flags[3]),
        .cnt      (cnt_b),
        .ovf_flag (ovf_b),
        .hit_flag (cmp_b),
        .wrap     (wrap_b),
        .match    (match_b)
    );

    // Capture register for the primary count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_val <= '0;
        else if (cap_evt) cap_val <= cnt_a;
    end

    dtm_pwm u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap_b),
        .match   (match_b),
        .oe      (ctrl_q.pwm_oe),
        .inv     (ctrl_q.pwm_inv),
        .level   (pwm_lvl),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/dtm_split_timer_chk.sv
// Property checker for dtm_split_timer, attached by bind. It observes
// ports and internal qualifiers only.
module dtm_split_timer_chk
    import dtm_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic [3:0]   clr_flags,
    input ctrl_t        ctrl_q,
    input logic [W-1:0] rel_a,
    input logic [W-1:0] cmpv_a,
    input logic [W-1:0] cnt_a,
    input logic         ovf_a,
    input logic         hit_a,
    input logic [W-1:0] cap_val,
    input logic         edge_hit,
    input logic         wrap_a,
    input logic         match_a,
    input logic [W-1:0] rel_b,
    input logic [W-1:0] cmpv_b,
    input logic [W-1:0] cnt_b,
    input logic         pwm_lvl
);
    logic tmr_a;
    logic capm;
    always_comb begin
        tmr_a = ctrl_q.run_a && !ctrl_q.cnt_mode && tick_en;
        capm  = (ctrl_q.edge_sel != EDGE_NONE) && !ctrl_q.cnt_mode;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_a && (cnt_a != '1) |=> cnt_a == W'($past(cnt_a) + 1'b1));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_a && (cnt_a == '1) |=> (cnt_a == $past(rel_a)) && ovf_a);

    p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_a |=> ovf_a);

    p_no_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !capm && (cmpv_a < rel_a) && !hit_a |=> !hit_a);

    p_match_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |=> hit_a && (cnt_a == $past(cmpv_a)));

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capm && edge_hit |=> (cap_val == $past(cnt_a)) && hit_a);

    p_hit_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a && !clr_flags[1] |=> hit_a);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_a && !clr_flags[0] |=> ovf_a);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run_a |=> $stable(cnt_a));

    p_pwm_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.run_b && tick_en && (cnt_b != '1) && (W'(cnt_b + 1'b1) == cmpv_b)
        && (cmpv_b >= rel_b) |=> !pwm_lvl);

    p_pwm_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.run_b && tick_en && (cnt_b == '1) && (rel_b != cmpv_b) |=> pwm_lvl);
endmodule

bind dtm_split_timer dtm_split_timer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .clr_flags (clr_flags),
    .ctrl_q    (ctrl_q),
    .rel_a     (rel_a),
    .cmpv_a    (cmpv_a),
    .cnt_a     (cnt_a),
    .ovf_a     (ovf_a),
    .hit_a     (hit_a),
    .cap_val   (cap_val),
    .edge_hit  (edge_hit),
    .wrap_a    (wrap_a),
    .match_a   (match_a),
    .rel_b     (rel_b),
    .cmpv_b    (cmpv_b),
    .cnt_b     (cnt_b),
    .pwm_lvl   (pwm_lvl)
);

// File: tb/sim_dtm_split_timer.sv
// Bench for dtm_split_timer: reload/compare sweeps, edge-select sweeps,
// capture, PWM shaping and flag clearing, with arithmetic expectations.
module sim_dtm_split_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         evt_pin = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [3:0]   clr_flags = '0;
    logic [W-1:0] cnt_a, cnt_b, cap_val;
    logic         ovf_a, hit_a, ovf_b, cmp_b, pwm_out;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtm_split_timer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_pin(evt_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_flags(clr_flags), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .cap_val(cap_val), .ovf_a(ovf_a), .hit_a(hit_a), .ovf_b(ovf_b),
        .cmp_b(cmp_b), .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr(input logic [3:0] v);
        @(negedge clk);
        clr_flags = v;
        @(negedge clk);
        clr_flags = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; evt_pin = 1'b0; wr_en = 1'b0; clr_flags = '0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rl [3];
        logic [7:0] cv [4];
        rl[0] = 8'h10; rl[1] = 8'hF0; rl[2] = 8'hFE;

        // R1: reset state
        do_reset();
        idle(1);
        chk("R1 cnt_a", cnt_a, 0);
        chk("R1 cnt_b", cnt_b, 0);
        chk("R1 cap", cap_val, 0);
        chk("R1 flags", {ovf_a, hit_a, ovf_b, cmp_b}, 0);
        chk("R1 pwm", pwm_out, 0);

        // R2/R3/R10: reload and compare sweep around the suppression boundary
        for (int i = 0; i < 3; i++) begin
            cv[0] = rl[i] - 8'd1; cv[1] = rl[i]; cv[2] = rl[i] + 8'd1; cv[3] = 8'hFF;
            for (int j = 0; j < 4; j++) begin
                do_reset();
                wr(3'd0, rl[i]);
                wr(3'd1, cv[j]);
                wr(3'd4, 8'h01);
                tick(255);
                chk("R2 count to top", cnt_a, 8'hFF);
                chk("R2 no ovf before wrap", ovf_a, 0);
                chk("R3 hit first pass", hit_a, (cv[j] >= rl[i]));
                clr(4'b0011);
                tick(1);
                chk("R2 reload value", cnt_a, rl[i]);
                chk("R2 ovf set", ovf_a, 1);
                chk("R3 hit at reload", hit_a, (cv[j] == rl[i]));
                clr(4'b0011);
                tick(8'hFF - rl[i]);
                chk("R3 hit second pass", hit_a, (cv[j] > rl[i]));
                chk("R2 back to top", cnt_a, 8'hFF);
            end
        end

        // R8/R9: set beats clear, stickiness, hold when stopped
        do_reset();
        wr(3'd1, 8'h03);
        wr(3'd4, 8'h01);
        tick(2);
        chk("R3 before match", hit_a, 0);
        @(negedge clk);
        tick_en = 1'b1; clr_flags = 4'b0010;
        @(negedge clk);
        tick_en = 1'b0; clr_flags = '0;
        chk("R8 set over clear", hit_a, 1);
        clr(4'b0010);
        chk("R8 clear", hit_a, 0);
        tick(1);
        chk("R8 stays clear", hit_a, 0);
        tick(255);
        chk("R2 wrapped count", cnt_a, 8'h03);
        chk("R8 sticky hit", hit_a, 1);
        chk("R8 sticky ovf", ovf_a, 1);
        wr(3'd4, 8'h00);
        tick(10);
        chk("R9 hold", cnt_a, 8'h03);

        // R4: counter mode under each edge selection, ticks ignored
        for (int sel = 0; sel < 4; sel++) begin
            do_reset();
            wr(3'd4, 8'h05 | 8'(sel << 3));
            @(negedge clk);
            tick_en = 1'b1;
            evt_pin = 1'b1;
            idle(2);
            if (sel == 1) chk("R4 latency before", cnt_a, 0);
            idle(1);
            if (sel == 1) chk("R4 latency at third edge", cnt_a, 1);
            idle(1);
            evt_pin = 1'b0;
            idle(4);
            for (int p = 0; p < 3; p++) begin
                evt_pin = 1'b1; idle(4);
                evt_pin = 1'b0; idle(4);
            end
            idle(4);
            tick_en = 1'b0;
            chk("R4 edge total", cnt_a, ((sel & 1) ? 4 : 0) + ((sel & 2) ? 4 : 0));
        end

        // R5: capture on rising edge, compare suppressed, falling ignored
        do_reset();
        wr(3'd1, 8'h05);
        wr(3'd4, 8'h09);
        tick(10);
        chk("R5 compare suppressed", hit_a, 0);
        @(negedge clk);
        evt_pin = 1'b1;
        idle(2);
        chk("R5 no capture yet", hit_a, 0);
        idle(1);
        chk("R5 capture value", cap_val, 8'd10);
        chk("R5 capture flag", hit_a, 1);
        clr(4'b0010);
        tick(5);
        @(negedge clk);
        evt_pin = 1'b0;
        idle(4);
        chk("R5 falling ignored flag", hit_a, 0);
        chk("R5 falling ignored value", cap_val, 8'd10);
        chk("R5 count kept", cnt_a, 8'd15);

        // R6/R7: secondary PWM while primary captures
        do_reset();
        wr(3'd2, 8'hF0);
        wr(3'd3, 8'hF8);
        wr(3'd4, 8'h2A);
        tick(247);
        chk("R6 cnt_b", cnt_b, 8'hF7);
        chk("R6 no cmp yet", cmp_b, 0);
        chk("R7 pwm before wrap", pwm_out, 0);
        tick(1);
        chk("R6 cmp_b set", cmp_b, 1);
        tick(8);
        chk("R6 reload b", cnt_b, 8'hF0);
        chk("R6 ovf_b", ovf_b, 1);
        chk("R7 pwm high after wrap", pwm_out, 1);
        clr(4'b1100);
        @(negedge clk);
        evt_pin = 1'b1;
        idle(3);
        chk("R5 capture during pwm", hit_a, 1);
        chk("R7 pwm unaffected", pwm_out, 1);
        tick(7);
        chk("R7 pwm high before match", pwm_out, 1);
        tick(1);
        chk("R7 pwm low at match", pwm_out, 0);
        chk("R6 cmp_b again", cmp_b, 1);
        wr(3'd4, 8'h6A);
        chk("R7 inverted", pwm_out, 1);
        wr(3'd4, 8'h4A);
        chk("R7 disabled", pwm_out, 0);
        chk("R10 ctrl write keeps b", cnt_b, 8'hF8);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule